// File: doc/BRIEF.md
# Program Counter Sequencer with Flag Branches and Stack Linkage

This block owns the 16-bit fetch address of a small processor core. Each accepted instruction arrives already decoded as a branch class, a two-bit flag condition, a 16-bit operand and a byte length. For ordinary and idle instructions the block moves the fetch address forward by the length. For jumps it loads the operand, either always or only when the selected zero or carry flag test passes.

Subroutine entry and exit go through a stack pointer and a byte-wide memory port. A call stores its return address as two bytes in two busy cycles before moving to the subroutine. A return reads the two bytes back in two busy cycles and resumes at the stored address. A halt instruction steps past itself and then freezes the fetch address until a resume pulse arrives.

Top module: `pc_branch_unit`

## Requirements
- R1: After reset the fetch address is RESET_PC (default 0x0000), the stack pointer is RESET_SP (default 0x0100), and busy, halted, memWe and memRe are all low.
- R2: An accepted instruction of class 0 (advance, used for no-op and ordinary instructions), or of the unused classes 6 and 7, sets the fetch address to the old address plus instLen one cycle after acceptance.
- R3: An accepted instruction of class 1 (unconditional jump) sets the fetch address to target one cycle after acceptance.
- R4: An accepted instruction of class 2 (conditional jump) loads target when its condition holds and otherwise advances by instLen; condition 0 holds when flagZ is 1, 1 when flagZ is 0, 2 when flagC is 1, 3 when flagC is 0.
- R5: An accepted instruction of class 3 (call) writes the high byte of (address + instLen) to stack pointer minus 1 in the first cycle after acceptance, and the low byte to stack pointer minus 2 in the second; the stack pointer ends 2 lower and the fetch address becomes target one cycle after the second write.
- R6: An accepted instruction of class 4 (return) reads the low byte at the stack pointer in the first cycle after acceptance and the high byte at stack pointer plus 1 in the second, with memRdata taken in the same cycle; the fetch address becomes {high, low} and the stack pointer ends 2 higher.
- R7: busy is high exactly during the two memory cycles of a call or return, the fetch address does not change in the first of them, and instValid is ignored while busy.
- R8: An accepted instruction of class 5 (halt) advances the fetch address by instLen and raises halted; while halted, instValid is ignored and the fetch address holds; a resume pulse clears halted one cycle later.
- R9: memWe and memRe are never high together, and both stay low outside the busy cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Decoded instruction presented this cycle |
| brType | input | 3 | Branch class (see R2 to R8) |
| cond | input | 2 | Flag condition for class 2 (see R4) |
| target | input | 16 | Jump or call destination |
| instLen | input | 3 | Instruction length in bytes |
| flagZ | input | 1 | Zero flag |
| flagC | input | 1 | Carry flag |
| resume | input | 1 | Leaves the halted state |
| pc | output | 16 | Current fetch address |
| sp | output | 16 | Current stack pointer |
| busy | output | 1 | Push or pop in progress |
| halted | output | 1 | Halted, waiting for resume |
| memWe | output | 1 | Stack byte write strobe |
| memRe | output | 1 | Stack byte read strobe |
| memAddr | output | 16 | Stack byte address |
| memWdata | output | 8 | Byte being written |
| memRdata | input | 8 | Byte read, valid in the same cycle as memRe |

## Verification
The assertions assume the stack memory answers a read combinationally in the cycle memRe is high, and that flags and operands are steady in the cycle an instruction is accepted. They also assume nothing outside the block moves the stack pointer, so each push is paired with a later pop. The bench models the memory as a small byte array read without delay, changes inputs only on falling edges, and deliberately keeps instValid high during busy and halted cycles to show those requests fall away.

// File: rtl/bu_pkg.sv
package bu_pkg;

  // branch class codes presented on brType
  typedef enum logic [2:0] {
    BR_ADV   = 3'd0,
    BR_JUMP  = 3'd1,
    BR_JCOND = 3'd2,
    BR_CALL  = 3'd3,
    BR_RET   = 3'd4,
    BR_HALT  = 3'd5
  } brType_e;

  // flag conditions for conditional jumps
  typedef enum logic [1:0] {
    CC_ZSET = 2'd0,
    CC_ZCLR = 2'd1,
    CC_CSET = 2'd2,
    CC_CCLR = 2'd3
  } cond_e;

  // source of the next fetch address
  typedef enum logic [2:0] {
    PC_HOLD = 3'd0,
    PC_SEQ  = 3'd1,
    PC_JMP  = 3'd2,
    PC_CALL = 3'd3,
    PC_POP  = 3'd4
  } pcSel_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH_HI = 3'd1,
    ST_PUSH_LO = 3'd2,
    ST_POP_LO  = 3'd3,
    ST_POP_HI  = 3'd4,
    ST_HALT    = 3'd5
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    pcSel_e pcSel;
    logic   latchCall;
    logic   spDec;
    logic   spInc;
    logic   memWe;
    logic   memRe;
    logic   wrHi;
    logic   capLo;
  } strobe_t;

endpackage

// File: rtl/bu_ctrl.sv
module bu_ctrl
  import bu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instValid,
  input  logic [2:0] brType,
  input  logic [1:0] cond,
  input  logic       flagZ,
  input  logic       flagC,
  input  logic       resume,
  output strobe_t    strb,
  output logic       busy,
  output logic       halted
);

  state_e state, stateNext;
  logic   condTrue;

  always_comb begin
    case (cond_e'(cond))
      CC_ZSET: condTrue = flagZ;
      CC_ZCLR: condTrue = !flagZ;
      CC_CSET: condTrue = flagC;
      default: condTrue = !flagC;
    endcase
  end

  always_comb begin
    strb       = '0;
    strb.pcSel = PC_HOLD;
    stateNext  = state;
    case (state)
      ST_IDLE: begin
        if (instValid) begin
          case (brType_e'(brType))
            BR_JUMP:  strb.pcSel = PC_JMP;
            BR_JCOND: strb.pcSel = condTrue ? PC_JMP : PC_SEQ;
            BR_CALL: begin
              strb.latchCall = 1'b1;
              stateNext      = ST_PUSH_HI;
            end
            BR_RET:   stateNext = ST_POP_LO;
            BR_HALT: begin
              strb.pcSel = PC_SEQ;
              stateNext  = ST_HALT;
            end
            default:  strb.pcSel = PC_SEQ;
          endcase
        end
      end
      ST_PUSH_HI: begin
        strb.memWe = 1'b1;
        strb.spDec = 1'b1;
        strb.wrHi  = 1'b1;
        stateNext  = ST_PUSH_LO;
      end
      ST_PUSH_LO: begin
        strb.memWe = 1'b1;
        strb.spDec = 1'b1;
        strb.pcSel = PC_CALL;
        stateNext  = ST_IDLE;
      end
      ST_POP_LO: begin
        strb.memRe = 1'b1;
        strb.spInc = 1'b1;
        strb.capLo = 1'b1;
        stateNext  = ST_POP_HI;
      end
      ST_POP_HI: begin
        strb.memRe = 1'b1;
        strb.spInc = 1'b1;
        strb.pcSel = PC_POP;
        stateNext  = ST_IDLE;
      end
      ST_HALT: begin
        if (resume) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy   = (state == ST_PUSH_HI) || (state == ST_PUSH_LO) ||
                  (state == ST_POP_LO)  || (state == ST_POP_HI);
  assign halted = (state == ST_HALT);

  // R5: the high-byte write is always followed by the low-byte write
  p_push_order_r5: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_PUSH_HI |=> state == ST_PUSH_LO);

  // R6: the low-byte read is always followed by the high-byte read
  p_pop_order_r6: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_POP_LO |=> state == ST_POP_HI);

  // R9: never read and write the stack in one cycle
  p_mem_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.memWe && strb.memRe));

  // R9: stack port quiet outside push/pop
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !strb.memWe && !strb.memRe);

endmodule

// File: rtl/bu_datapath.sv
module bu_datapath
  import bu_pkg::*;
#(
  parameter int ADDR_W             = 16,
  parameter int LEN_W              = 3,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  parameter logic [ADDR_W-1:0] RESET_SP = 16'h0100
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strb,
  input  logic [ADDR_W-1:0]      target,
  input  logic [LEN_W-1:0]       instLen,
  input  logic [ADDR_W/2-1:0]    memRdata,
  output logic [ADDR_W-1:0]      pc,
  output logic [ADDR_W-1:0]      sp,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [ADDR_W/2-1:0]    memWdata
);

  localparam int HALF_W = ADDR_W / 2;

  logic [ADDR_W-1:0] pcSeq, pcNext, retAddr, callTgt;
  logic [HALF_W-1:0] popLo;

  assign pcSeq = pc + ADDR_W'(instLen);

  always_comb begin
    case (strb.pcSel)
      PC_SEQ:  pcNext = pcSeq;
      PC_JMP:  pcNext = target;
      PC_CALL: pcNext = callTgt;
      PC_POP:  pcNext = {memRdata, popLo};
      default: pcNext = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc      <= RESET_PC;
      sp      <= RESET_SP;
      retAddr <= '0;
      callTgt <= '0;
      popLo   <= '0;
    end else begin
      pc <= pcNext;
      if (strb.spDec)      sp <= sp - ADDR_W'(1);
      else if (strb.spInc) sp <= sp + ADDR_W'(1);
      if (strb.latchCall) begin
        retAddr <= pcSeq;
        callTgt <= target;
      end
      if (strb.capLo) popLo <= memRdata;
    end
  end

  assign memAddr  = strb.memWe ? (sp - ADDR_W'(1)) : sp;
  assign memWdata = strb.wrHi ? retAddr[ADDR_W-1:HALF_W] : retAddr[HALF_W-1:0];

  // R5: each push cycle lowers the stack pointer by one
  p_push_dec_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.memWe |=> sp == $past(sp) - ADDR_W'(1));

  // R6: each pop cycle raises the stack pointer by one
  p_pop_inc_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.memRe |=> sp == $past(sp) + ADDR_W'(1));

  // R6: pop reads happen at the current stack pointer
  p_pop_addr_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.memRe |-> memAddr == sp);

endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
  import bu_pkg::*;
#(
  parameter int ADDR_W             = 16,
  parameter int LEN_W              = 3,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  parameter logic [ADDR_W-1:0] RESET_SP = 16'h0100
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                instValid,
  input  logic [2:0]          brType,
  input  logic [1:0]          cond,
  input  logic [ADDR_W-1:0]   target,
  input  logic [LEN_W-1:0]    instLen,
  input  logic                flagZ,
  input  logic                flagC,
  input  logic                resume,
  output logic [ADDR_W-1:0]   pc,
  output logic [ADDR_W-1:0]   sp,
  output logic                busy,
  output logic                halted,
  output logic                memWe,
  output logic                memRe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [ADDR_W/2-1:0] memWdata,
  input  logic [ADDR_W/2-1:0] memRdata
);

  strobe_t strb;

  bu_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid),
    .brType    (brType),
    .cond      (cond),
    .flagZ     (flagZ),
    .flagC     (flagC),
    .resume    (resume),
    .strb      (strb),
    .busy      (busy),
    .halted    (halted)
  );

  bu_datapath #(
    .ADDR_W   (ADDR_W),
    .LEN_W    (LEN_W),
    .RESET_PC (RESET_PC),
    .RESET_SP (RESET_SP)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .target   (target),
    .instLen  (instLen),
    .memRdata (memRdata),
    .pc       (pc),
    .sp       (sp),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

  assign memWe = strb.memWe;
  assign memRe = strb.memRe;

  // R8: fetch address frozen while halted
  p_halt_freeze_r8: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> $stable(pc));

  // R7: fetch address unchanged on entry to a busy sequence
  p_entry_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $stable(pc));

  // R1: nothing is busy and nothing halted straight out of reset
  p_reset_idle_r1: assert property (@(posedge clk)
    !$past(rstN) |-> !busy && !halted);

endmodule

// File: tb/tb_pc_branch_unit.sv
module tb_pc_branch_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [2:0]  brType = 3'd0;
  logic [1:0]  cond = 2'd0;
  logic [15:0] target = 16'h0;
  logic [2:0]  instLen = 3'd1;
  logic        flagZ = 1'b0;
  logic        flagC = 1'b0;
  logic        resume = 1'b0;
  logic [15:0] pc, sp, memAddr;
  logic        busy, halted, memWe, memRe;
  logic [7:0]  memWdata, memRdata;

  logic [7:0]  mem [0:255];
  int          checks = 0;
  int          errors = 0;
  logic [15:0] expPc;

  always #10 clk = ~clk;

  pc_branch_unit dut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .brType(brType),
    .cond(cond), .target(target), .instLen(instLen), .flagZ(flagZ),
    .flagC(flagC), .resume(resume), .pc(pc), .sp(sp), .busy(busy),
    .halted(halted), .memWe(memWe), .memRe(memRe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  assign memRdata = mem[memAddr[7:0]];
  always @(negedge clk) if (memWe) mem[memAddr[7:0]] <= memWdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // present one instruction for one cycle; returns at the falling edge after acceptance
  task automatic issue(input logic [2:0] t, input logic [1:0] c,
                       input logic [15:0] tgt, input logic [2:0] len);
    @(negedge clk);
    instValid = 1'b1; brType = t; cond = c; target = tgt; instLen = len;
    @(negedge clk);
    instValid = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 pc", pc, 16'h0000);
    chk("R1 sp", sp, 16'h0100);
    chk("R1 busy/halted", {busy, halted}, 2'b00);
    chk("R1 mem strobes", {memWe, memRe}, 2'b00);
    expPc = 16'h0000;
  endtask

  task automatic testAdvance();
    issue(3'd0, 2'd0, 16'hDEAD, 3'd1); expPc += 16'd1; chk("R2 len1", pc, expPc);
    issue(3'd0, 2'd0, 16'hDEAD, 3'd2); expPc += 16'd2; chk("R2 len2", pc, expPc);
    issue(3'd0, 2'd0, 16'hDEAD, 3'd3); expPc += 16'd3; chk("R2 len3", pc, expPc);
    issue(3'd7, 2'd0, 16'hDEAD, 3'd2); expPc += 16'd2; chk("R2 unused class", pc, expPc);
    issue(3'd6, 2'd0, 16'hDEAD, 3'd4); expPc += 16'd4; chk("R2 unused class 6", pc, expPc);
  endtask

  task automatic testJump();
    issue(3'd1, 2'd1, 16'h1234, 3'd3); expPc = 16'h1234; chk("R3 jump", pc, expPc);
  endtask

  task automatic testCond();
    for (int c = 0; c < 4; c++) begin
      for (int f = 0; f < 2; f++) begin
        logic taken;
        logic [15:0] tgt;
        flagZ = f[0]; flagC = ~f[0];
        taken = (c == 0 && flagZ) || (c == 1 && !flagZ) || (c == 2 && flagC) || (c == 3 && !flagC);
        tgt = 16'h2000 + 16'(c * 16 + f);
        issue(3'd2, 2'(c), tgt, 3'd3);
        expPc = taken ? tgt : expPc + 16'd3;
        chk($sformatf("R4 cond=%0d z=%0d c=%0d", c, flagZ, flagC), pc, expPc);
      end
    end
    flagZ = 1'b0; flagC = 1'b0;
  endtask

  task automatic testCall(input logic [15:0] tgt);
    logic [15:0] ret;
    ret = expPc + 16'd3;
    issue(3'd3, 2'd0, tgt, 3'd3);
    // request a jump while busy; it must be dropped
    instValid = 1'b1; brType = 3'd1; target = 16'h7777; instLen = 3'd1;
    chk("R7 busy push1", busy, 1'b1);
    chk("R7 pc held push1", pc, expPc);
    chk("R5 we push1", {memWe, memRe}, 2'b10);
    chk("R5 addr hi", memAddr, 16'h00FF);
    chk("R5 data hi", memWdata, ret[15:8]);
    @(negedge clk);
    chk("R5 addr lo", memAddr, 16'h00FE);
    chk("R5 data lo", memWdata, ret[7:0]);
    @(negedge clk);
    instValid = 1'b0;
    chk("R7 busy drop", busy, 1'b0);
    chk("R5 pc target", pc, tgt);
    chk("R5 sp", sp, 16'h00FE);
    chk("R9 idle strobes", {memWe, memRe}, 2'b00);
    chk("R5 stack bytes", {mem[8'hFF], mem[8'hFE]}, ret);
    expPc = tgt;
  endtask

  task automatic testRet(input logic [15:0] ret);
    issue(3'd4, 2'd0, 16'hBEEF, 3'd1);
    instValid = 1'b1; brType = 3'd1; target = 16'h5555;
    chk("R7 busy pop1", busy, 1'b1);
    chk("R6 re pop1", {memWe, memRe}, 2'b01);
    chk("R6 addr lo", memAddr, 16'h00FE);
    @(negedge clk);
    chk("R6 addr hi", memAddr, 16'h00FF);
    @(negedge clk);
    instValid = 1'b0;
    chk("R6 pc return", pc, ret);
    chk("R6 sp", sp, 16'h0100);
    chk("R7 busy end", busy, 1'b0);
    expPc = ret;
  endtask

  task automatic testHalt();
    issue(3'd5, 2'd0, 16'h0, 3'd1);
    expPc += 16'd1;
    chk("R8 halted", halted, 1'b1);
    chk("R8 pc step", pc, expPc);
    instValid = 1'b1; brType = 3'd1; target = 16'h3333;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 pc frozen", pc, expPc);
    end
    instValid = 1'b0;
    resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
    chk("R8 resumed", halted, 1'b0);
    chk("R8 pc after resume", pc, expPc);
    issue(3'd0, 2'd0, 16'h0, 3'd2);
    expPc += 16'd2;
    chk("R8 advance after resume", pc, expPc);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testAdvance();
    testJump();
    testCond();
    issue(3'd1, 2'd0, 16'h0ABC, 3'd3); expPc = 16'h0ABC;
    testCall(16'h4000);
    testRet(16'h0ABF);
    issue(3'd1, 2'd0, 16'h12F0, 3'd3); expPc = 16'h12F0;
    testCall(16'h6010);
    testRet(16'h12F3);
    testHalt();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule